// File: doc/BRIEF.md
# End-Around-Carry Prefix Modulo Adder

This block is a purely combinational n-bit adder that works modulo 2^n−1 or modulo 2^n+1. A logarithmic-depth parallel-prefix network forms the carry-out of A+B with no carry-in. One more prefix level then folds a fed-back carry into every bit position. This last level acts as a fast output incrementer. No combinational loop forms, and the block needs only one adder.

A two-bit mode input selects how the fed-back carry is formed:

- modulo 2^n−1 where all-ones is a second encoding of zero,
- modulo 2^n−1 with a single zero,
- modulo 2^n+1 on diminished-one operands.

The raw carry-out and the full-width group propagate are exposed so that a surrounding datapath can detect overflow and the all-ones sum. The width is a parameter.

Top module: `eac_modadd`

## Requirements
- R1: Mode 0 (double-zero modulo 2^n−1): sum_o equals (A+B+cout) mod 2^n. The result is congruent to A+B modulo 2^n−1.
- R2: Mode 1 (single-zero modulo 2^n−1): for operands in 0..2^n−2, sum_o equals (A+B) mod (2^n−1) and never shows all-ones.
- R3: Mode 1: when A+B equals exactly 2^n−1 (all sum bits propagate), sum_o is all zeros.
- R4: Mode 2 (modulo 2^n+1, diminished-one): sum_o equals ((A+B+1) mod (2^n+1)) mod 2^n. This is the diminished-one sum of the operands that A and B represent.
- R5: cout_o is bit n of the plain sum A+B in every mode, unaffected by the fed-back carry.
- R6: pall_o is 1 exactly when A XOR B is all ones, in every mode.
- R7: Mode encoding 3 behaves exactly like mode 0.
- R8: Mode 0 returns the all-ones pattern when A+B equals 2^n−1, for example A=0 and B=all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| mode_i | input | 2 | Feedback mode: 0 double-zero 2^n−1, 1 single-zero 2^n−1, 2 diminished-one 2^n+1, 3 as 0 |
| sum_o | output | WIDTH | Modulo sum |
| cout_o | output | 1 | Carry-out of A+B without carry-in |
| pall_o | output | 1 | Group propagate over all bits |

## Verification
The bench builds two copies of the adder. The first, at WIDTH=8, is swept over every operand pair in all four mode encodings. That sweep reaches every carry-out and all-propagate combination, the all-ones wrap of the single-zero mode and the 2^n−1 boundary of the diminished-one mode. The second, at WIDTH=16, takes random operands plus chosen edge values. It exercises a prefix tree with four full levels, where an error in the span of a combining node would stay hidden in the smaller build.

// File: rtl/eac_pkg.sv
package eac_pkg;
  typedef enum logic [1:0] {
    EAC_M1_DZ  = 2'd0,
    EAC_M1_SZ  = 2'd1,
    EAC_P1_DM1 = 2'd2,
    EAC_ALT_DZ = 2'd3
  } eac_mode_e;
endpackage

// File: rtl/eac_pregen.sv
module eac_pregen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);
  // bitwise generate and propagate
  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;
endmodule

// File: rtl/eac_prefix_tree.sv
module eac_prefix_tree #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] grp_g_o,
  output logic [WIDTH-1:0] grp_p_o
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;

  // Minimum-depth tree: at level l, each bit whose index has bit l-1 set
  // absorbs the group ending just below its aligned block of size 2^(l-1).
  for (genvar l = 0; l <= LEVELS; l++) begin : lv
    logic [WIDTH-1:0] gg;
    logic [WIDTH-1:0] pp;
    if (l == 0) begin : g_seed
      assign gg = g_i;
      assign pp = p_i;
    end else begin : g_lvl
      for (genvar i = 0; i < WIDTH; i++) begin : bt
        if (((i >> (l - 1)) & 1) == 1) begin : g_node
          localparam int J = ((i >> (l - 1)) << (l - 1)) - 1;
          assign gg[i] = lv[l-1].gg[i] | (lv[l-1].pp[i] & lv[l-1].gg[J]);
          assign pp[i] = lv[l-1].pp[i] & lv[l-1].pp[J];
        end else begin : g_pass
          assign gg[i] = lv[l-1].gg[i];
          assign pp[i] = lv[l-1].pp[i];
        end
      end
    end
  end

  assign grp_g_o = lv[LEVELS].gg;
  assign grp_p_o = lv[LEVELS].pp;
endmodule

// File: rtl/eac_feedback.sv
module eac_feedback
  import eac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  eac_mode_e        mode_i,
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] grp_g_i,
  input  logic [WIDTH-1:0] grp_p_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             pall_o
);
  logic             raw_cout;
  logic             all_prop;
  logic             cin_fb;
  logic [WIDTH:0]   carry;

  assign raw_cout = grp_g_i[WIDTH-1];
  assign all_prop = grp_p_i[WIDTH-1];

  always_comb begin
    case (mode_i)
      EAC_M1_SZ:  cin_fb = raw_cout | all_prop;
      EAC_P1_DM1: cin_fb = ~raw_cout;
      default:    cin_fb = raw_cout;
    endcase
  end

  // extra prefix level: one operator node per bit merges the fed-back carry
  assign carry[0] = cin_fb;
  for (genvar i = 0; i < WIDTH; i++) begin : g_inc
    assign carry[i+1] = grp_g_i[i] | (grp_p_i[i] & cin_fb);
  end

  assign sum_o  = p_i ^ carry[WIDTH-1:0];
  assign cout_o = raw_cout;
  assign pall_o = all_prop;
endmodule

// File: rtl/eac_modadd.sv
module eac_modadd
  import eac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             pall_o
);
  logic [WIDTH-1:0] gen_bits;
  logic [WIDTH-1:0] prop_bits;
  logic [WIDTH-1:0] grp_gen;
  logic [WIDTH-1:0] grp_prop;
  eac_mode_e        mode_sel;

  assign mode_sel = eac_mode_e'(mode_i);

  eac_pregen #(.WIDTH(WIDTH)) u_pre (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (gen_bits),
    .p_o (prop_bits)
  );

  eac_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .g_i     (gen_bits),
    .p_i     (prop_bits),
    .grp_g_o (grp_gen),
    .grp_p_o (grp_prop)
  );

  eac_feedback #(.WIDTH(WIDTH)) u_fb (
    .mode_i  (mode_sel),
    .p_i     (prop_bits),
    .grp_g_i (grp_gen),
    .grp_p_i (grp_prop),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .pall_o  (pall_o)
  );
endmodule

// File: rtl/eac_modadd_chk.sv
module eac_modadd_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             pall_o
);
  logic [WIDTH:0]   plain;
  logic [WIDTH-1:0] inc_lo;
  logic [WIDTH:0]   dm1_ref;

  assign plain   = {1'b0, a_i} + {1'b0, b_i};
  assign inc_lo  = plain[WIDTH-1:0] + {{(WIDTH-1){1'b0}}, plain[WIDTH]};
  assign dm1_ref = plain[WIDTH] ? (plain - {1'b1, {WIDTH{1'b0}}})
                                : (plain + {{WIDTH{1'b0}}, 1'b1});

  always_comb begin
    // R5
    cout_raw_chk: assert (cout_o == plain[WIDTH])
      else $error("cout_o differs from carry of plain sum");
    // R6
    pall_full_chk: assert (pall_o == ((a_i ^ b_i) == {WIDTH{1'b1}}))
      else $error("pall_o differs from all-propagate condition");
    // R1
    dz_sum_chk: assert (!(mode_i == 2'd0 || mode_i == 2'd3) || sum_o == inc_lo)
      else $error("double-zero sum wrong");
    // R3
    sz_wrap_chk: assert (!(mode_i == 2'd1 && pall_o) || sum_o == '0)
      else $error("single-zero wrap not zero");
    // R4
    dm1_sum_chk: assert (mode_i != 2'd2 || sum_o == dm1_ref[WIDTH-1:0])
      else $error("diminished-one sum wrong");
  end
endmodule

bind eac_modadd eac_modadd_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .mode_i (mode_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .pall_o (pall_o)
);

// File: tb/tb_eac_modadd.sv
module tb_eac_modadd;
  localparam int WS = 8;
  localparam int WL = 16;
  localparam int WDOG_LIMIT = 150000;

  logic clk;
  logic rst_n;
  int   total = 0;
  int   bad = 0;
  int   cycles = 0;
  bit   done = 0;

  logic [WS-1:0] a_s, b_s, sum_s;
  logic [1:0]    mode_s;
  logic          cout_s, pall_s;
  logic [WL-1:0] a_l, b_l, sum_l;
  logic [1:0]    mode_l;
  logic          cout_l, pall_l;

  eac_modadd #(.WIDTH(WS)) dut (
    .a_i(a_s), .b_i(b_s), .mode_i(mode_s),
    .sum_o(sum_s), .cout_o(cout_s), .pall_o(pall_s)
  );

  eac_modadd #(.WIDTH(WL)) dut_w16 (
    .a_i(a_l), .b_i(b_l), .mode_i(mode_l),
    .sum_o(sum_l), .cout_o(cout_l), .pall_o(pall_l)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WDOG_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected values from arithmetic on the requirements
  task automatic judge(input int w, input longint a, input longint b, input int mode,
                       input longint s, input longint c, input longint p);
    longint m   = longint'(1) << w;
    longint raw = a + b;
    longint ec  = raw >> w;
    longint ep  = ((a ^ b) == (m - 1)) ? 1 : 0;
    chk("R5 cout", c, ec);
    chk("R6 pall", p, ep);
    case (mode)
      0: begin
        chk("R1 dz sum", s, (raw + ec) % m);
        chk("R1 dz congruence", s % (m - 1), raw % (m - 1));
      end
      3: chk("R7 mode3 as dz", s, (raw + ec) % m);
      1: begin
        if (a < m - 1 && b < m - 1) begin
          if (raw == m - 1) chk("R3 sz wrap", s, 0);
          else              chk("R2 sz sum", s, raw % (m - 1));
        end else begin
          chk("R2 sz congruence", s % (m - 1), raw % (m - 1));
        end
      end
      default: chk("R4 dm1 sum", s, ((raw + 1) % (m + 1)) % m);
    endcase
  endtask

  initial begin
    rst_n = 1'b0;
    a_s = '0; b_s = '0; mode_s = 2'd0;
    a_l = '0; b_l = '0; mode_l = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset-time operand state: zero in, zero out (R1)
    chk("R1 zero out", longint'(sum_s), 0);
    chk("R5 zero cout", longint'(cout_s), 0);
    rst_n = 1'b1;

    // R8 double zero produces the all-ones encoding
    a_s = 8'h00; b_s = 8'hFF; mode_s = 2'd0;
    #1 chk("R8 all-ones zero", longint'(sum_s), 255);
    // R3 explicit single-zero wrap
    a_s = 8'h0F; b_s = 8'hF0; mode_s = 2'd1;
    #1 chk("R3 explicit wrap", longint'(sum_s), 0);
    // R4 boundary A+B = 2^n-1
    a_s = 8'h80; b_s = 8'h7F; mode_s = 2'd2;
    #1 chk("R4 boundary", longint'(sum_s), 0);

    // exhaustive small build
    for (int md = 0; md < 4; md++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int bi = 0; bi < 256; bi++) begin
          a_s = ai[7:0]; b_s = bi[7:0]; mode_s = md[1:0];
          #1;
          judge(WS, ai, bi, md, longint'(sum_s), longint'(cout_s), longint'(pall_s));
        end
      end
    end

    // wide build: edges then random
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 3000; k++) begin
        logic [WL-1:0] ra, rb;
        ra = WL'($urandom);
        rb = WL'($urandom);
        if (k == 0) begin ra = '1; rb = '0; end
        if (k == 1) begin ra = '1; rb = '1; end
        if (k == 2) begin ra = 16'h5555; rb = 16'hAAAA; end
        if (k == 3) begin ra = 16'h8000; rb = 16'h8000; end
        if (k == 4) begin ra = 16'hFFFE; rb = 16'h0001; end
        a_l = ra; b_l = rb; mode_l = md[1:0];
        #1;
        judge(WL, longint'(ra), longint'(rb), md,
              longint'(sum_l), longint'(cout_l), longint'(pall_l));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule